// File: doc/BRIEF.md
# PCM Codec Serial Port Controller

This block is the digital serial port of a telephony PCM codec running in synchronous mode. Everything runs on the master clock. The bit clock, the two frame syncs and the shared receive-clock/power-down pin are sampled on that clock, and their edges are found by comparing each sample with the one before.

On each transmit frame sync the block latches the 8-bit sample that the encoder prepared in the previous frame. It then drives that sample MSB first, one bit per rising bit-clock edge, on a serial output. A separate enable signal controls the external tri-state buffer for that output. On each receive frame sync it shifts in 8 bits from the serial input, one on each falling bit-clock edge, MSB first. It then presents the byte on a parallel bus with a single-cycle valid strobe.

The block powers up when the shared pin is low or is toggling. It powers down when the pin has sat high with no edge for a set number of master-clock cycles. After any power-up, the serial output stays released until the second transmit frame sync. The analog-output enable follows the power state.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dout_en`, `aout_en` and `rx_valid` are 0 and the block is powered down.
- R2: A low level on `pdn_pin`, or any edge on it, sets `aout_en` to 1 one clock later. When `pdn_pin` is high with no edge for IDLE_CYCLES (default 16) consecutive clocks, `aout_en` falls to 0 on the clock that completes that count.
- R3: After power-up, the first transmit frame sync loads nothing and `dout_en` stays 0. Shifting starts from the second transmit frame sync and continues for every sync after that.
- R4: After an armed frame sync latches `tx_sample`, each rising bit-clock edge puts the next bit on `dout`, MSB first, and sets `dout_en`. `dout` changes on no other edge.
- R5: The ninth rising bit-clock edge after an armed frame sync clears `dout_en`.
- R6: After a receive frame sync, `din` is shifted in on each of the next 8 falling bit-clock edges, MSB first. `rx_data` then holds the byte, and `rx_valid` is high for exactly one clock.
- R7: A transmit frame sync that arrives during a shift reloads `tx_sample` and restarts the bit count. The next 8 rising edges carry the new sample.
- R8: Power-down clears `dout_en` and `aout_en` on the same clock and clears the frame-sync count. After the next power-up the first sync is again silent.
- R9: A frame sync counts once per low-to-high transition of its sampled value, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pdn_pin | input | 1 | Shared receive master clock / power-down level |
| bclk | input | 1 | Bit clock, synchronous to clk |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| tx_sample | input | 8 | Encoded sample to transmit |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_en | output | 1 | Drive enable for the external tri-state buffer on dout |
| aout_en | output | 1 | Analog output enable (powered-up state) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |

## Verification
Each result is registered once after the input edge that causes it. A transmit bit appears one clock after the clock that first samples `bclk` high. `rx_valid` appears one clock after the eighth sampled fall. `aout_en` rises one clock after a low or changed pin sample, and falls on the clock that completes the IDLE_CYCLES count after the last pin edge. The bench holds every input steady across a rising clock edge and compares all outputs with a behavioural reference model at each falling edge. The directed checks sample `dout` one clock after each `bclk` rise they drive, so they read each bit in the cycle it is due.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // frame-sync counter used by the second-pulse arming rule
  typedef logic [1:0] fs_count_t;
  localparam fs_count_t FS_NONE  = 2'd0;
  localparam fs_count_t FS_ONE   = 2'd1;
  localparam fs_count_t FS_ARMED = 2'd2;
endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = sig[i] & ~prev[i];
    assign fall[i] = ~sig[i] & prev[i];
  end
endmodule

// File: rtl/pcm_pwr_detect.sv
module pcm_pwr_detect #(
  parameter int IDLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pwr_on_next,
  output logic pwr_on
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_CYCLES);

  logic          pin_q;
  logic [CW-1:0] idle_cnt, idle_cnt_n;
  logic          pin_edge;

  assign pin_edge    = pin ^ pin_q;
  assign idle_cnt_n  = pin_edge ? '0 : ((idle_cnt == LIM) ? idle_cnt : idle_cnt + 1'b1);
  assign pwr_on_next = !(pin && (idle_cnt_n == LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b1;
      idle_cnt <= LIM;
      pwr_on   <= 1'b0;
    end else begin
      pin_q    <= pin;
      idle_cnt <= idle_cnt_n;
      pwr_on   <= pwr_on_next;
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_on,
  input  logic         fs_rise,
  input  logic         bclk_rise,
  input  logic [W-1:0] sample,
  output logic         dout,
  output logic         dout_en
);
  localparam int CW = $clog2(W + 1);

  fs_count_t     fs_seen;
  logic [W-1:0]  shreg;
  logic [CW-1:0] bits;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_seen <= FS_NONE;
      shreg   <= '0;
      bits    <= '0;
      active  <= 1'b0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else if (!pwr_on) begin
      fs_seen <= FS_NONE;
      active  <= 1'b0;
      dout_en <= 1'b0;
    end else if (fs_rise) begin
      if (fs_seen != FS_ARMED) fs_seen <= fs_seen + 1'b1;
      if (fs_seen != FS_NONE) begin
        shreg  <= sample;
        bits   <= '0;
        active <= 1'b1;
      end
    end else if (bclk_rise && active) begin
      if (bits < CW'(W)) begin
        dout    <= shreg[W-1];
        shreg   <= {shreg[W-2:0], 1'b0};
        dout_en <= 1'b1;
        bits    <= bits + 1'b1;
      end else begin
        dout_en <= 1'b0;
        active  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_on,
  input  logic         fs_rise,
  input  logic         bclk_fall,
  input  logic         din,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!pwr_on) begin
        active <= 1'b0;
      end else if (fs_rise) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (bclk_fall && active) begin
        shreg <= {shreg[W-2:0], din};
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          rx_data  <= {shreg[W-2:0], din};
          rx_valid <= 1'b1;
          active   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int SAMPLE_W    = 8,
  parameter int IDLE_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pdn_pin,
  input  logic                bclk,
  input  logic                fs_tx,
  input  logic                fs_rx,
  input  logic [SAMPLE_W-1:0] tx_sample,
  input  logic                din,
  output logic                dout,
  output logic                dout_en,
  output logic                aout_en,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);
  localparam int NSIG  = 3;
  localparam int I_BCK = 0;
  localparam int I_FTX = 1;
  localparam int I_FRX = 2;

  logic [NSIG-1:0] rise, fall;
  logic            pwr_on_next, pwr_on;

  pcm_edge_detect #(.N(NSIG)) u_edges (
    .clk (clk),
    .rst (rst),
    .sig ({fs_rx, fs_tx, bclk}),
    .rise(rise),
    .fall(fall)
  );

  pcm_pwr_detect #(.IDLE_CYCLES(IDLE_CYCLES)) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .pin        (pdn_pin),
    .pwr_on_next(pwr_on_next),
    .pwr_on     (pwr_on)
  );

  pcm_tx_shift #(.W(SAMPLE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .pwr_on   (pwr_on_next),
    .fs_rise  (rise[I_FTX]),
    .bclk_rise(rise[I_BCK]),
    .sample   (tx_sample),
    .dout     (dout),
    .dout_en  (dout_en)
  );

  pcm_rx_shift #(.W(SAMPLE_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .pwr_on   (pwr_on_next),
    .fs_rise  (rise[I_FRX]),
    .bclk_fall(fall[I_BCK]),
    .din      (din),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  assign aout_en = pwr_on;
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic pdn_pin,
  input logic bclk,
  input logic dout,
  input logic dout_en,
  input logic aout_en,
  input logic rx_valid
);
  // R1: the cycle after reset shows the powered-down, idle state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!dout_en && !aout_en && !rx_valid));

  // R2: a low pin powers the block up one clock later
  assert_low_pin_powers_R2: assert property (@(posedge clk) disable iff (rst)
    !pdn_pin |=> aout_en);

  // R8: the output is never driven while powered down
  assert_quiet_when_down_R8: assert property (@(posedge clk) disable iff (rst)
    !aout_en |-> !dout_en);

  // R4: serial data moves only on a bit-clock rise
  assert_dout_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $stable(bclk) |=> $stable(dout));

  // R6: the receive strobe lasts a single clock
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pdn_pin (pdn_pin),
  .bclk    (bclk),
  .dout    (dout),
  .dout_en (dout_en),
  .aout_en (aout_en),
  .rx_valid(rx_valid)
);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int IDLE       = 16;

  logic clk = 1'b0;
  logic rst, pdn_pin, bclk, fs_tx, fs_rx, din;
  logic [7:0] tx_sample;
  logic dout, dout_en, aout_en, rx_valid;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rst(rst), .pdn_pin(pdn_pin), .bclk(bclk), .fs_tx(fs_tx),
    .fs_rx(fs_rx), .tx_sample(tx_sample), .din(din), .dout(dout),
    .dout_en(dout_en), .aout_en(aout_en), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pq, m_idle, m_bq, m_tq, m_rq;
  int m_pu, m_fs, m_txact, m_bits, m_en, m_dout;
  int m_rxact, m_rcnt, m_rv, m_rxd, m_rsh;
  logic [7:0] m_tsh;

  always @(posedge clk) begin
    int pu_n, br, bf, tr, rr;
    if (rst) begin
      m_pq = 1; m_idle = IDLE; m_bq = 0; m_tq = 0; m_rq = 0;
      m_pu = 0; m_fs = 0; m_txact = 0; m_bits = 0; m_en = 0; m_dout = 0;
      m_rxact = 0; m_rcnt = 0; m_rv = 0; m_rxd = 0; m_rsh = 0; m_tsh = 0;
    end else begin
      if (int'(pdn_pin) != m_pq) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
      m_pq = int'(pdn_pin);
      pu_n = (pdn_pin && m_idle == IDLE) ? 0 : 1;
      br = (bclk && m_bq == 0); bf = (!bclk && m_bq == 1); m_bq = int'(bclk);
      tr = (fs_tx && m_tq == 0); m_tq = int'(fs_tx);
      rr = (fs_rx && m_rq == 0); m_rq = int'(fs_rx);
      m_rv = 0;
      if (!pu_n) begin
        m_fs = 0; m_txact = 0; m_en = 0; m_rxact = 0;
      end else begin
        if (tr) begin
          if (m_fs < 2) m_fs++;
          if (m_fs >= 2) begin m_tsh = tx_sample; m_txact = 1; m_bits = 0; end
        end else if (br && m_txact) begin
          if (m_bits < 8) begin
            m_dout = m_tsh[7]; m_tsh = m_tsh << 1; m_en = 1; m_bits++;
          end else begin
            m_en = 0; m_txact = 0;
          end
        end
        if (rr) begin
          m_rxact = 1; m_rcnt = 0;
        end else if (bf && m_rxact) begin
          m_rsh = ((m_rsh << 1) | int'(din)) & 8'hFF;
          m_rcnt++;
          if (m_rcnt == 8) begin m_rxd = m_rsh; m_rv = 1; m_rxact = 0; end
        end
      end
      m_pu = pu_n;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(aout_en === 1'(m_pu), "R2 aout_en", int'(aout_en), m_pu);
      chk(dout_en === 1'(m_en), "R3/R5 dout_en", int'(dout_en), m_en);
      if (m_en) chk(dout === 1'(m_dout), "R4 dout", int'(dout), m_dout);
      chk(rx_valid === 1'(m_rv), "R6 rx_valid", int'(rx_valid), m_rv);
      chk(rx_data === 8'(m_rxd), "R6 rx_data", int'(rx_data), m_rxd);
    end
  end

  logic [7:0] last_rx;
  always @(negedge clk) if (rx_valid) last_rx = rx_data;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [7:0] got;
  bit en_any, en_after;

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one frame: sync of width fsw, then nrise bit-clock periods of 4 clocks
  task automatic frame(input logic [7:0] smp, input logic [7:0] rxb,
                       input int fsw, input int nrise);
    got = '0; en_any = 0; en_after = 0;
    @(negedge clk);
    tx_sample = smp; bclk = 0; fs_tx = 1; fs_rx = 1;
    wait_clk(fsw);
    fs_tx = 0; fs_rx = 0;
    for (int i = 0; i < nrise; i++) begin
      bclk = 1; din = (i < 8) ? rxb[7-i] : 1'b0;
      @(negedge clk);
      if (i < 8) begin
        got[7-i] = dout;
        if (dout_en) en_any = 1;
      end else begin
        en_after = dout_en;
      end
      @(negedge clk);
      bclk = 0;
      wait_clk(2);
    end
    wait_clk(2);
  endtask

  initial begin
    rst = 1; pdn_pin = 1; bclk = 0; fs_tx = 0; fs_rx = 0; din = 0; tx_sample = 0;
    last_rx = 0;
    wait_clk(4);
    rst = 0;
    @(negedge clk);
    chk(!dout_en && !aout_en && !rx_valid, "R1 reset state",
        {dout_en, aout_en, rx_valid}, 0);

    wait_clk(30);
    chk(aout_en == 1'b0, "R2 static high stays down", int'(aout_en), 0);
    pdn_pin = 0;
    wait_clk(2);
    chk(aout_en == 1'b1, "R2 low level powers up", int'(aout_en), 1);

    // first sync after power-up, held high for many clocks: silent
    frame(8'hA5, 8'h3C, 12, 9);
    chk(en_any == 0, "R3 first sync silent", int'(en_any), 0);
    chk(en_any == 0, "R9 long sync counted once", int'(en_any), 0);
    chk(last_rx == 8'h3C, "R6 received byte", int'(last_rx), 8'h3C);

    frame(8'hA5, 8'hC9, 2, 9);
    chk(en_any == 1 && got == 8'hA5, "R4 MSB-first A5", int'(got), 8'hA5);
    chk(en_after == 0, "R5 release on ninth rise", int'(en_after), 0);
    chk(last_rx == 8'hC9, "R6 received byte", int'(last_rx), 8'hC9);

    frame(8'h81, 8'h7E, 2, 9);
    chk(got == 8'h81, "R4 MSB-first 81", int'(got), 8'h81);

    // restart in the middle of a shift
    frame(8'hF0, 8'h00, 2, 3);
    frame(8'h0F, 8'h5A, 2, 9);
    chk(got == 8'h0F, "R7 restart loads new sample", int'(got), 8'h0F);
    chk(en_after == 0, "R7 restart still ends after eight", int'(en_after), 0);

    // running clock on the pin keeps the block up
    for (int i = 0; i < 40; i++) begin pdn_pin = ~pdn_pin; @(negedge clk); end
    chk(aout_en == 1'b1, "R2 running clock keeps power", int'(aout_en), 1);
    pdn_pin = 1;
    wait_clk(10);
    chk(aout_en == 1'b1, "R2 not yet idle", int'(aout_en), 1);
    wait_clk(10);
    chk(aout_en == 1'b0, "R2 idle high powers down", int'(aout_en), 0);

    // power-down in the middle of a shift
    pdn_pin = 0;
    wait_clk(2);
    frame(8'h11, 8'h22, 2, 9);
    frame(8'hAA, 8'h33, 2, 3);
    pdn_pin = 1;
    wait_clk(17);
    chk(dout_en == 0 && aout_en == 0, "R8 powered down releases output",
        {dout_en, aout_en}, 0);
    pdn_pin = 0;
    wait_clk(2);
    frame(8'h55, 8'h44, 2, 9);
    chk(en_any == 0, "R8 sync count cleared", int'(en_any), 0);
    frame(8'h55, 8'h66, 2, 9);
    chk(got == 8'h55, "R8 output resumes on second sync", int'(got), 8'h55);

    wait_clk(4);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule